// File: doc/BRIEF.md
# Fuse-Trim Serial Access Slave

This block is the device-side controller for a three-pin serial port (chip select, clock, bidirectional data) that reaches a one-time-programmable trim register of 54 bits. The pins normally belong to the sensor's angle readout. A dedicated entry sequence gives them to the trim logic, and a dedicated exit sequence gives them back. While access is open, every rising edge of chip select starts one operation. The levels of the clock and data pins at that edge choose the operation: copy fuses into the shadow register, shift new shadow data in, stream the shadow data out, or burn fuses.

The fuse cells are modelled as sticky bits preset to a factory value. Their content is copied into the shadow register on the first cycle after power-up reset. While burning, the high phase of the serial clock is the burn strobe and the low phase is a recharge gap. A burn pass can be turned into an analog check pass, in which only the index of the cell under measurement advances. All three pins are sampled by the system clock through a synchroniser, so every serial edge becomes a one-cycle event.

Top module: `otp_trim_slave`

## Requirements
- R1: Right after reset the trim output equals the preset fuse content within two system cycles, access is closed and the data-pin output enable is low.
- R2: Access opens only after this sequence: a chip-select rise with clock low and data high, followed by a clock rise while chip select is low. A chip-select rise with any other levels leaves access closed.
- R3: While access is open, two clock rises with chip select low close access again. A single such rise does not.
- R4: At a chip-select rise inside access, the operation is decoded from {clock, data}: 00 load, 01 write, 10 read, 11 burn.
- R5: In load, the k-th clock rise copies fuse bit k-1 into shadow bit k-1, counting from bit 0. Bits not yet reached keep their value.
- R6: In write, the first 54 clock rises shift the data pin in, and the first bit ends in bit 53. The shadow register does not change until the 55th rise, which copies the staged word. Later rises are ignored.
- R7: In read, the output enable rises on the second clock rise and the data output shows bit 53. Each later rise steps one bit lower, and after bit 0 the output wraps to bit 53.
- R8: The output enable is never high outside access, and it drops when chip select falls.
- R9: In burn, the first four clock falls are a preamble. If data is high at the fourth fall, the i-th following clock high phase drives the burn strobe for bit i (i = 0, 1, ...) exactly when shadow bit i is 1, and that fuse becomes 1.
- R10: A burned fuse stays 1 for good. A burn pulse on a bit whose shadow value is 0 leaves that fuse as it was.
- R11: If data is low at the fourth clock fall of a burn pass, the pass becomes an analog check. The next clock rise selects index 0, each later rise adds one, the select output is high only during clock high, and the burn strobe stays low.
- R12: When the chip-select rise and a clock rise land in the same sample, the clock edge is not counted as a data edge, and the operation is decoded with clock = 1.
- R13: While access is closed, pin activity changes neither the trim output nor the output enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low power-up reset |
| csn_i | input | 1 | Serial chip select, active low |
| sclk_i | input | 1 | Serial clock and burn strobe |
| pdio_i | input | 1 | Serial data pin, input side |
| pdio_o | output | 1 | Serial data pin, output side |
| pdio_oe_o | output | 1 | Output enable for the data pin |
| otp_mode_o | output | 1 | High while the pins are held by trim access |
| trim_o | output | 54 | Shadow trim register |
| burn_o | output | 1 | Fuse burn current enable |
| ana_sel_o | output | 1 | Analog check cell select, high during clock high |
| ana_idx_o | output | 6 | Index of the cell under analog check |

## Verification
The chip-select rise that decodes an operation and a clock rise that advances it can fall in the same synchroniser sample. The bench provokes this by raising both pins in the same time step with data low. After that, one more clock pulse must leave the output enable low and a second must raise it with bit 53 shown. This proves that the merged edge was not counted and that read was decoded. A second overlap, a burn strobe next to the analog select, is held apart by checking the burn output at every clock high of the analog pass.

// File: rtl/otp_trim_pkg.sv
package otp_trim_pkg;

    localparam int PIN_CSN  = 0;
    localparam int PIN_SCLK = 1;
    localparam int PIN_PDIO = 2;
    localparam int PIN_CNT  = 3;

    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_ARMED,
        ACC_OPEN
    } acc_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_LOAD,
        OP_WRITE,
        OP_READ,
        OP_PROG,
        OP_ANA,
        OP_DONE
    } op_e;

    function automatic op_e decode_op(input logic clk_lvl, input logic dat_lvl);
        case ({clk_lvl, dat_lvl})
            2'b00:   return OP_LOAD;
            2'b01:   return OP_WRITE;
            2'b10:   return OP_READ;
            default: return OP_PROG;
        endcase
    endfunction

endpackage

// File: rtl/otp_pin_edges.sv
module otp_pin_edges #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic csn_i,
    input  logic sclk_i,
    input  logic pdio_i,
    output logic csn_lvl_o,
    output logic sclk_lvl_o,
    output logic pdio_lvl_o,
    output logic csn_rise_o,
    output logic csn_fall_o,
    output logic sclk_rise_o,
    output logic sclk_fall_o
);
    import otp_trim_pkg::*;

    localparam logic [PIN_CNT-1:0] PIN_IDLE = PIN_CNT'(1) << PIN_CSN;

    logic [SYNC_STAGES:0][PIN_CNT-1:0] pipe_q;
    logic [PIN_CNT-1:0] pins;
    logic [PIN_CNT-1:0] cur;
    logic [PIN_CNT-1:0] prv;

    always_comb begin
        pins           = '0;
        pins[PIN_CSN]  = csn_i;
        pins[PIN_SCLK] = sclk_i;
        pins[PIN_PDIO] = pdio_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= {(SYNC_STAGES+1){PIN_IDLE}};
        else         pipe_q <= {pipe_q[SYNC_STAGES-1:0], pins};
    end

    assign cur = pipe_q[SYNC_STAGES-1];
    assign prv = pipe_q[SYNC_STAGES];

    assign csn_lvl_o   = cur[PIN_CSN];
    assign sclk_lvl_o  = cur[PIN_SCLK];
    assign pdio_lvl_o  = cur[PIN_PDIO];
    assign csn_rise_o  =  cur[PIN_CSN]  & ~prv[PIN_CSN];
    assign csn_fall_o  = ~cur[PIN_CSN]  &  prv[PIN_CSN];
    assign sclk_rise_o =  cur[PIN_SCLK] & ~prv[PIN_SCLK];
    assign sclk_fall_o = ~cur[PIN_SCLK] &  prv[PIN_SCLK];

endmodule

// File: rtl/otp_fuse_bank.sv
module otp_fuse_bank #(
    parameter int          WIDTH     = 54,
    parameter logic [WIDTH-1:0] FUSE_INIT = '0,
    localparam int         IW        = $clog2(WIDTH)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             burn_i,
    input  logic [IW-1:0]    idx_i,
    input  logic             val_i,
    output logic [WIDTH-1:0] fuse_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                fuse_o[i] <= FUSE_INIT[i];
            end else if (burn_i && val_i && (idx_i == IW'(i))) begin
                fuse_o[i] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/otp_trim_slave.sv
module otp_trim_slave #(
    parameter int               WIDTH       = 54,
    parameter int               SYNC_STAGES = 2,
    parameter logic [WIDTH-1:0] FUSE_INIT   = '0,
    localparam int              IW          = $clog2(WIDTH),
    localparam int              CW          = $clog2(WIDTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             csn_i,
    input  logic             sclk_i,
    input  logic             pdio_i,
    output logic             pdio_o,
    output logic             pdio_oe_o,
    output logic             otp_mode_o,
    output logic [WIDTH-1:0] trim_o,
    output logic             burn_o,
    output logic             ana_sel_o,
    output logic [IW-1:0]    ana_idx_o
);
    import otp_trim_pkg::*;

    localparam logic [CW-1:0] CNT_FULL  = CW'(WIDTH);
    localparam logic [IW-1:0] IDX_LAST  = IW'(WIDTH - 1);
    localparam logic [2:0]    PRE_FALLS = 3'd4;

    typedef struct packed {
        acc_e             acc;
        op_e              op;
        logic             boot;
        logic             ext;
        logic [2:0]       pre;
        logic [CW-1:0]    cnt;
        logic             oe;
        logic [IW-1:0]    ptr;
        logic             ana_on;
        logic [IW-1:0]    aidx;
        logic             burn;
        logic             ana_sel;
        logic [WIDTH-1:0] shadow;
        logic [WIDTH-1:0] sreg;
    } ctl_t;

    ctl_t q, d;

    logic csn_lvl, sclk_lvl, pdio_lvl;
    logic csn_rise, csn_fall, sclk_rise, sclk_fall;
    logic [WIDTH-1:0] fuse_bits;
    logic             burn_fire;
    logic [IW-1:0]    cidx;
    logic             cnt_ok;

    otp_pin_edges #(.SYNC_STAGES(SYNC_STAGES)) u_edges (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .csn_i       (csn_i),
        .sclk_i      (sclk_i),
        .pdio_i      (pdio_i),
        .csn_lvl_o   (csn_lvl),
        .sclk_lvl_o  (sclk_lvl),
        .pdio_lvl_o  (pdio_lvl),
        .csn_rise_o  (csn_rise),
        .csn_fall_o  (csn_fall),
        .sclk_rise_o (sclk_rise),
        .sclk_fall_o (sclk_fall)
    );

    otp_fuse_bank #(.WIDTH(WIDTH), .FUSE_INIT(FUSE_INIT)) u_fuses (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .burn_i (burn_fire),
        .idx_i  (cidx),
        .val_i  (q.shadow[cidx]),
        .fuse_o (fuse_bits)
    );

    assign cidx   = IW'(q.cnt);
    assign cnt_ok = (q.cnt < CNT_FULL);

    always_comb begin
        d         = q;
        burn_fire = 1'b0;
        if (q.boot) begin
            d.shadow = fuse_bits;
            d.boot   = 1'b0;
        end
        unique case (q.acc)
            ACC_IDLE: begin
                if (csn_rise && !sclk_lvl && pdio_lvl) d.acc = ACC_ARMED;
            end
            ACC_ARMED: begin
                if (csn_rise) begin
                    d.acc = ACC_IDLE;
                end else if (sclk_rise && !csn_lvl) begin
                    d.acc = ACC_OPEN;
                    d.op  = OP_NONE;
                    d.ext = 1'b0;
                end
            end
            ACC_OPEN: begin
                if (csn_rise) begin
                    d.op     = decode_op(sclk_lvl, pdio_lvl);
                    d.cnt    = '0;
                    d.pre    = '0;
                    d.ext    = 1'b0;
                    d.oe     = 1'b0;
                    d.ana_on = 1'b0;
                end else if (csn_fall) begin
                    d.op = OP_NONE;
                    d.oe = 1'b0;
                end else if (!csn_lvl) begin
                    if (sclk_rise) begin
                        if (q.ext) begin
                            d.acc = ACC_IDLE;
                            d.ext = 1'b0;
                        end else begin
                            d.ext = 1'b1;
                        end
                    end
                end else begin
                    case (q.op)
                        OP_LOAD: if (sclk_rise && cnt_ok) begin
                            d.shadow[cidx] = fuse_bits[cidx];
                            d.cnt          = q.cnt + 1'b1;
                        end
                        OP_WRITE: if (sclk_rise) begin
                            if (cnt_ok) begin
                                d.sreg = {q.sreg[WIDTH-2:0], pdio_lvl};
                                d.cnt  = q.cnt + 1'b1;
                            end else begin
                                d.shadow = q.sreg;
                                d.op     = OP_DONE;
                            end
                        end
                        OP_READ: if (sclk_rise) begin
                            if (q.cnt == '0) begin
                                d.cnt = q.cnt + 1'b1;
                            end else if (!q.oe) begin
                                d.oe  = 1'b1;
                                d.ptr = IDX_LAST;
                            end else begin
                                d.ptr = (q.ptr == '0) ? IDX_LAST : q.ptr - 1'b1;
                            end
                        end
                        OP_PROG: if (sclk_fall) begin
                            if (q.pre != PRE_FALLS) begin
                                d.pre = q.pre + 3'd1;
                                if (q.pre == PRE_FALLS - 3'd1 && !pdio_lvl) d.op = OP_ANA;
                            end else if (cnt_ok) begin
                                burn_fire = 1'b1;
                                d.cnt     = q.cnt + 1'b1;
                            end
                        end
                        OP_ANA: if (sclk_rise) begin
                            if (!q.ana_on) begin
                                d.ana_on = 1'b1;
                                d.aidx   = '0;
                            end else if (q.aidx != IDX_LAST) begin
                                d.aidx = q.aidx + 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            default: d.acc = ACC_IDLE;
        endcase
        d.burn    = (q.acc == ACC_OPEN) && (q.op == OP_PROG) && (q.pre == PRE_FALLS)
                    && csn_lvl && sclk_lvl && cnt_ok && q.shadow[cidx];
        d.ana_sel = (q.acc == ACC_OPEN) && (q.op == OP_ANA) && q.ana_on
                    && csn_lvl && sclk_lvl;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q      <= '0;
            q.boot <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign pdio_o     = q.oe ? q.shadow[q.ptr] : 1'b0;
    assign pdio_oe_o  = q.oe;
    assign otp_mode_o = (q.acc == ACC_OPEN);
    assign trim_o     = q.shadow;
    assign burn_o     = q.burn;
    assign ana_sel_o  = q.ana_sel;
    assign ana_idx_o  = q.aidx;

endmodule

// File: rtl/otp_trim_sva.sv
module otp_trim_sva #(
    parameter int  WIDTH = 54,
    localparam int IW    = $clog2(WIDTH)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             csn_lvl,
    input logic             otp_mode_o,
    input logic             pdio_oe_o,
    input logic             burn_o,
    input logic             ana_sel_o,
    input logic [IW-1:0]    ana_idx_o,
    input logic [WIDTH-1:0] trim_o,
    input logic [WIDTH-1:0] fuse_bits,
    input logic             boot
);
    localparam logic [IW-1:0] IDX_LAST = IW'(WIDTH - 1);

    AST_OE_IN_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pdio_oe_o |-> otp_mode_o); // R8

    AST_OE_DROP_ON_CSN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(csn_lvl) |=> !pdio_oe_o); // R8

    AST_FUSE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((fuse_bits & $past(fuse_bits)) == $past(fuse_bits))); // R10

    AST_BURN_NOT_ANALOG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        burn_o |-> (otp_mode_o && !ana_sel_o)); // R9

    AST_ANA_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ana_idx_o <= IDX_LAST); // R11

    AST_TRIM_HOLD_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!otp_mode_o && !boot) |=> $stable(trim_o)); // R13

endmodule

bind otp_trim_slave otp_trim_sva #(.WIDTH(WIDTH)) u_sva (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .csn_lvl    (csn_lvl),
    .otp_mode_o (otp_mode_o),
    .pdio_oe_o  (pdio_oe_o),
    .burn_o     (burn_o),
    .ana_sel_o  (ana_sel_o),
    .ana_idx_o  (ana_idx_o),
    .trim_o     (trim_o),
    .fuse_bits  (fuse_bits),
    .boot       (q.boot)
);

// File: tb/otp_trim_slave_tb.sv
module otp_trim_slave_tb;

    localparam int          N    = 54;
    localparam logic [N-1:0] FI  = 54'h2A5;
    localparam logic [N-1:0] V   = 54'h2D_1234_5678_9A8A;
    localparam logic [N-1:0] FB  = FI | (V & 54'h3F);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csn = 1'b1, sclk = 1'b0, pdio = 1'b0;
    logic pdio_o, pdio_oe, otp_mode, burn, ana_sel;
    logic [N-1:0] trim;
    logic [5:0] ana_idx;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    otp_trim_slave #(.WIDTH(N), .FUSE_INIT(FI)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .csn_i(csn), .sclk_i(sclk), .pdio_i(pdio),
        .pdio_o(pdio_o), .pdio_oe_o(pdio_oe), .otp_mode_o(otp_mode), .trim_o(trim),
        .burn_o(burn), .ana_sel_o(ana_sel), .ana_idx_o(ana_idx)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        repeat (6) @(posedge clk);
        #1;
    endtask

    task automatic pulse();
        sclk = 1'b1; step();
        sclk = 1'b0; step();
    endtask

    task automatic start_op(input logic c, input logic dv);
        sclk = c; pdio = dv; step();
        csn = 1'b1; step();
        sclk = 1'b0; step();
    endtask

    task automatic end_op();
        csn = 1'b0; step();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; repeat (3) @(posedge clk); #1;
        rst_n = 1'b1; step();
        chk("R1", "trim after power-up", 64'(trim), 64'(FI));
        chk("R1", "access closed", 64'(otp_mode), 64'd0);
        chk("R1", "oe low", 64'(pdio_oe), 64'd0);
    endtask

    task automatic t_closed_ignored();
        csn = 1'b0; step();
        sclk = 1'b1; step();
        csn = 1'b1; step();
        pulse(); pulse();
        chk("R13", "oe while closed", 64'(pdio_oe), 64'd0);
        chk("R13", "trim while closed", 64'(trim), 64'(FI));
        csn = 1'b0; step();
        csn = 1'b1; step();
        csn = 1'b0; step();
        pulse();
        chk("R2", "wrong setup levels keep access closed", 64'(otp_mode), 64'd0);
    endtask

    task automatic t_enter();
        csn = 1'b0; sclk = 1'b0; step();
        pdio = 1'b1; step();
        csn = 1'b1; step();
        csn = 1'b0; step();
        chk("R2", "armed only, not open", 64'(otp_mode), 64'd0);
        sclk = 1'b1; step();
        sclk = 1'b0; pdio = 1'b0; step();
        chk("R2", "access open", 64'(otp_mode), 64'd1);
    endtask

    task automatic t_write();
        start_op(1'b0, 1'b1);
        for (int i = 0; i < N; i++) begin
            pdio = V[N-1-i]; step();
            pulse();
        end
        chk("R6", "shadow held while staging", 64'(trim), 64'(FI));
        pulse();
        chk("R4 R6", "write latched", 64'(trim), 64'(V));
        pdio = ~pdio; step();
        pulse();
        chk("R6", "rise after latch ignored", 64'(trim), 64'(V));
        end_op();
    endtask

    task automatic t_read();
        start_op(1'b1, 1'b0);
        pulse();
        chk("R7", "oe low after first rise", 64'(pdio_oe), 64'd0);
        pulse();
        chk("R4 R7", "oe high after second rise", 64'(pdio_oe), 64'd1);
        chk("R7", "first bit out", 64'(pdio_o), 64'(V[N-1]));
        for (int j = 1; j <= N + 1; j++) begin
            pulse();
            chk("R7", $sformatf("bit out step %0d", j), 64'(pdio_o),
                64'(V[(2*N-1-j) % N]));
        end
        end_op();
        chk("R8", "oe drops with chip select", 64'(pdio_oe), 64'd0);
    endtask

    task automatic t_merged_edge();
        pdio = 1'b0; step();
        csn = 1'b1; sclk = 1'b1; step();
        sclk = 1'b0; step();
        pulse();
        chk("R12", "merged edge not counted", 64'(pdio_oe), 64'd0);
        pulse();
        chk("R12", "read decoded with clock high", 64'(pdio_oe), 64'd1);
        chk("R12", "first bit after merged start", 64'(pdio_o), 64'(V[N-1]));
        end_op();
    endtask

    task automatic t_prog_and_load();
        start_op(1'b1, 1'b1);
        pulse(); pulse(); pulse();
        chk("R9", "no strobe in preamble", 64'(burn), 64'd0);
        for (int b = 0; b < 6; b++) begin
            sclk = 1'b1; step();
            chk("R4 R9", $sformatf("strobe bit %0d", b), 64'(burn), 64'(V[b]));
            sclk = 1'b0; step();
        end
        chk("R9", "strobe low in recharge gap", 64'(burn), 64'd0);
        end_op();
        start_op(1'b0, 1'b0);
        pulse(); pulse();
        chk("R4 R5", "two bits loaded", 64'(trim), 64'((V & ~54'h3) | (FB & 54'h3)));
        for (int k = 2; k < N; k++) pulse();
        chk("R5", "all bits loaded", 64'(trim), 64'(FB));
        chk("R10", "zero shadow bit left fuse unburned", 64'(trim[4]), 64'd0);
        chk("R10", "preset fuse stays burned", 64'(trim[0]), 64'd1);
        pulse();
        chk("R5", "extra rise no change", 64'(trim), 64'(FB));
        end_op();
    endtask

    task automatic t_analog();
        start_op(1'b1, 1'b1);
        pulse(); pulse();
        pdio = 1'b0; step();
        pulse();
        chk("R11", "no select before first rise", 64'(ana_sel), 64'd0);
        sclk = 1'b1; step();
        chk("R11", "select high", 64'(ana_sel), 64'd1);
        chk("R11", "index zero", 64'(ana_idx), 64'd0);
        chk("R11", "no burn in analog", 64'(burn), 64'd0);
        sclk = 1'b0; step();
        chk("R11", "select low in clock low", 64'(ana_sel), 64'd0);
        sclk = 1'b1; step();
        chk("R11", "index one", 64'(ana_idx), 64'd1);
        chk("R11", "no burn second high", 64'(burn), 64'd0);
        sclk = 1'b0; step();
        end_op();
    endtask

    task automatic t_exit();
        pulse();
        chk("R3", "one rise keeps access", 64'(otp_mode), 64'd1);
        pulse();
        chk("R3", "two rises close access", 64'(otp_mode), 64'd0);
        sclk = 1'b1; step();
        csn = 1'b1; step();
        sclk = 1'b0; step();
        pulse(); pulse(); pulse();
        chk("R13", "trim unchanged after exit", 64'(trim), 64'(FB));
        chk("R8", "oe low after exit", 64'(pdio_oe), 64'd0);
        csn = 1'b0; step();
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        finish_run();
    end

    initial begin
        t_reset();
        t_closed_ignored();
        t_enter();
        t_write();
        t_read();
        t_merged_edge();
        t_prog_and_load();
        t_analog();
        t_exit();
        finish_run();
    end

endmodule